// File: doc/BRIEF.md
# I2C Timekeeping Register Target

This block is the two-wire serial front end of a small timekeeping register file of twenty bytes: eight clock bytes (hundredths, seconds, minutes, hours, day, date, month, year), followed by control, watchdog, alarm, flag, reserved and square-wave bytes. It resynchronises the SCL and SDA lines onto a fast system clock and recognises START, repeated START and STOP. It answers one fixed 7-bit device address and keeps a word pointer that walks forward through the file as bytes are acknowledged. The pad is modelled as a separate input and a pull-low enable, so the line seen by the block is the wired-AND of the bus and its own drive.

A timekeeping core beside the block pushes fresh counter values into the eight clock bytes through an update port. While the host is positioned on the clock bytes, the block raises a freeze output and refuses those updates, so a multi-byte read returns one consistent instant. When the host writes any clock byte, the hundredths byte is cleared and a one-cycle divider-reset pulse tells the core to restart its prescaler. The clock bytes are also presented in parallel so the core can load the written time. A power-fail input aborts any transfer and keeps the block off the bus while it is held.

Top module: `i2c_tk_target`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits are 1101000 (D0h to write, D1h to read); any other address gets no acknowledge, and the block stays off the bus until the next START.
- R2: In a write, the first byte after the address loads the word pointer (a value of 20 or more loads 0); every later byte is acknowledged, stored at the pointer and moves the pointer forward by one.
- R3: In a read, the byte at the pointer is shifted out MSB first; a host ACK moves the pointer forward and the next byte follows, while a host NACK leaves the pointer on the byte just read.
- R4: A read that begins without a word address starts at the byte the pointer already holds.
- R5: The pointer advances from 19 (13h) to 0.
- R6: A write to any of the bytes 0 to 7 leaves byte 0 (hundredths) at 00h and gives exactly one one-cycle pulse on the divider-reset output; byte 0 itself can only be written to 00h.
- R7: Writes to bytes 15 to 18 (the flag byte and the three reserved bytes) are acknowledged but ignored; those bytes read 00h.
- R8: The freeze output is high while the block is addressed and the pointer is below 8, and falls on STOP or when the pointer reaches 8 or more; a clock update offered while freeze is high is dropped, and one offered while it is low is loaded into bytes 0 to 7.
- R9: While power-fail is high the block releases SDA, resets the pointer to 0, ends the transfer and acknowledges nothing; a byte interrupted this way is not written.
- R10: After a host NACK on a read byte the block releases SDA and does not drive it again before the next START.
- R11: After reset SDA is released, freeze and divider-reset are low, every byte is 00h and the pointer is 0.
- R12: The block never pulls SDA low while SCL is high during a bit that the host is sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when high |
| power_fail | input | 1 | Supply out of tolerance; aborts and ignores the bus |
| upd_en | input | 1 | One-cycle strobe carrying a new clock value |
| upd_time | input | 64 | New clock bytes, byte n in bits 8n+7..8n |
| freeze | output | 1 | Clock bytes held against updates |
| div_rst | output | 1 | One-cycle pulse after a clock byte write |
| tk_time | output | 64 | Current clock bytes, byte n in bits 8n+7..8n |

## Verification
A wrong pointer shows up on the first data byte of the next read, which returns the neighbour of the expected byte, so every read in the bench is compared against a behavioural byte image and pointer kept in the bench. A stuck or late freeze shows up as a clock update that either lands during a read or is lost afterwards, visible on the parallel clock bytes within two cycles of the update strobe. A protocol state that drifts out of step with the bus shows as an acknowledge in the wrong bit slot, which the bench catches on every system clock by watching SDA drive during host bits and during power fail.

// File: rtl/i2c_tk_pkg.sv
package i2c_tk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } tgt_state_t;

  localparam logic [6:0] TK_DEV_ADDR = 7'b1101000;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_bit
);

  logic [1:0] raw;
  logic [1:0] cur;
  logic [1:0] prv;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain  <= '1;
        prv[g] <= 1'b1;
      end else begin
        chain  <= {chain[STAGES-2:0], raw[g]};
        prv[g] <= chain[STAGES-1];
      end
    end
    assign cur[g] = chain[STAGES-1];
  end

  // index 0 is SCL, index 1 is SDA
  assign scl_rise = cur[0] & ~prv[0];
  assign scl_fall = ~cur[0] & prv[0];
  assign start_ev = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_ev  = cur[0] & prv[0] & ~prv[1] & cur[1];
  assign sda_bit  = cur[1];

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = TK_DEV_ADDR,
  parameter int NREG = 20,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          power_fail,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sda_bit,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] ptr,
  output logic          sel,
  output logic          sda_oe
);

  localparam logic [7:0]    NREG_B = 8'(NREG);
  localparam logic [AW-1:0] LAST   = AW'(NREG - 1);

  tgt_state_t    state;
  logic [3:0]    bcnt;
  logic [7:0]    sh;
  logic          rw;
  logic          mack;
  logic [AW-1:0] ptr_nx;

  assign ptr_nx  = (ptr == LAST) ? '0 : ptr + 1'b1;
  // while waiting for the host acknowledge, prefetch the following byte
  assign rd_addr = (state == ST_RDATA_ACK) ? ptr_nx : ptr;

  always_ff @(posedge clk) begin
    if (rst || power_fail) begin
      state  <= ST_IDLE;
      bcnt   <= '0;
      sh     <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      sel    <= 1'b0;
      sda_oe <= 1'b0;
      wr_en  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sel    <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_bit};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  sel    <= 1'b1;
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  sel   <= 1'b0;
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= (state == ST_WADDR) ? ST_WADDR_ACK : ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (rw) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              bcnt   <= '0;
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WADDR;
            end
          end
          ST_WADDR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            ptr    <= (sh < NREG_B) ? sh[AW-1:0] : '0;
            state  <= ST_WDATA;
          end
          ST_WDATA_ACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= sh;
            ptr     <= ptr_nx;
            state   <= ST_WDATA;
          end
          ST_RDATA: if (scl_fall) begin
            if (bcnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_RDATA_ACK;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[6:0], 1'b0};
              bcnt   <= bcnt + 1'b1;
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_bit;
            end else if (scl_fall) begin
              if (mack) begin
                ptr    <= ptr_nx;
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                bcnt   <= '0;
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  a_r5_ptr_in_file: assert property (@(posedge clk) disable iff (rst)
    ptr < AW'(NREG));

  a_r9_pf_quiet: assert property (@(posedge clk) disable iff (rst)
    power_fail |=> (!sda_oe && ptr == '0 && !sel));

  a_r3_nack_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDATA_ACK && scl_fall && !mack && !start_ev && !stop_ev && !power_fail)
      |=> $stable(ptr));

  a_r1_foreign_no_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && scl_fall && bcnt == 4'd8 && sh[7:1] != DEV_ADDR
      && !start_ev && !stop_ev && !power_fail) |=> !sda_oe);

endmodule

// File: rtl/tk_regfile.sv
module tk_regfile #(
  parameter int NREG   = 20,
  parameter int NCLK   = 8,
  parameter int RSV_LO = 15,
  parameter int RSV_HI = 18,
  localparam int AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              upd_en,
  input  logic [8*NCLK-1:0] upd_time,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic [8*NCLK-1:0] tk_time,
  output logic              div_rst
);

  localparam logic [AW-1:0] NCLK_A = AW'(NCLK);
  localparam logic [AW-1:0] LO_A   = AW'(RSV_LO);
  localparam logic [AW-1:0] HI_A   = AW'(RSV_HI);
  localparam logic [AW-1:0] NREG_A = AW'(NREG);

  logic [7:0] mem [NREG];
  logic       wr_ok;
  logic       wr_clk;

  assign wr_ok  = wr_en && (wr_addr < LO_A || wr_addr > HI_A);
  assign wr_clk = wr_ok && (wr_addr < NCLK_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      div_rst <= 1'b0;
    end else begin
      div_rst <= wr_clk;
      if (upd_en && !hold) begin
        for (int i = 0; i < NCLK; i++) mem[i] <= upd_time[8*i +: 8];
      end
      if (wr_ok) mem[wr_addr] <= (wr_addr == '0) ? 8'h00 : wr_data;
      if (wr_clk) mem[0] <= 8'h00;
    end
  end

  assign rd_data = (rd_addr < NREG_A) ? mem[rd_addr] : 8'h00;

  for (genvar g = 0; g < NCLK; g++) begin : g_time
    assign tk_time[8*g +: 8] = mem[g];
  end

  a_r6_clock_write_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < NCLK_A) |=> (mem[0] == 8'h00 && div_rst));

  a_r8_hold_blocks_update: assert property (@(posedge clk) disable iff (rst)
    (hold && !wr_en) |=> $stable(mem[1]));

endmodule

// File: rtl/i2c_tk_target.sv
module i2c_tk_target
  import i2c_tk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = TK_DEV_ADDR,
  parameter int NREG        = 20,
  parameter int NCLK        = 8,
  parameter int RSV_LO      = 15,
  parameter int RSV_HI      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              power_fail,
  input  logic              upd_en,
  input  logic [8*NCLK-1:0] upd_time,
  output logic              freeze,
  output logic              div_rst,
  output logic [8*NCLK-1:0] tk_time
);

  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] NCLK_A = AW'(NCLK);

  logic          scl_rise, scl_fall, start_ev, stop_ev, sda_bit;
  logic [7:0]    rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr, ptr;
  logic          wr_en, sel;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_bit(sda_bit)
  );

  i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_ctrl (
    .clk(clk), .rst(rst), .power_fail(power_fail),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_bit(sda_bit),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr(ptr), .sel(sel), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) freeze <= 1'b0;
    else     freeze <= sel && (ptr < NCLK_A);
  end

  tk_regfile #(.NREG(NREG), .NCLK(NCLK), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_regs (
    .clk(clk), .rst(rst), .hold(freeze),
    .upd_en(upd_en), .upd_time(upd_time),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .tk_time(tk_time), .div_rst(div_rst)
  );

endmodule

// File: tb/i2c_tk_target_tb.sv
module i2c_tk_target_tb_top;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        scl_m = 1'b1, sda_m = 1'b1, pf = 1'b0, upd_en = 1'b0;
  logic [63:0] upd_time = '0;
  logic        sda_oe, freeze, div_rst;
  logic [63:0] tk_time;
  logic        sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2c_tk_target dut_i (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .power_fail(pf), .upd_en(upd_en), .upd_time(upd_time),
    .freeze(freeze), .div_rst(div_rst), .tk_time(tk_time)
  );

  int n_chk = 0, n_fail = 0, div_seen = 0, div_exp = 0, ptr_m = 0;
  int mem_m [20];
  bit host_bit = 0, pf_settled = 0, done = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  // model of a host write landing in the byte image
  task automatic m_wr(int a, int d);
    if (!(a >= 15 && a <= 18)) begin
      mem_m[a] = (a == 0) ? 0 : d;
      if (a < 8) begin
        mem_m[0] = 0;
        div_exp++;
      end
    end
    ptr_m = (ptr_m == 19) ? 0 : ptr_m + 1;
  endtask

  task automatic apply_upd(logic [63:0] t, bit frozen);
    upd_time = t; upd_en = 1'b1; w(1); upd_en = 1'b0; w(2);
    if (!frozen) for (int i = 0; i < 8; i++) mem_m[i] = int'(t[8*i +: 8]);
  endtask

  task automatic bstart();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic bit_w(bit b);
    sda_m = b; w(Q); host_bit = 1'b1; scl_m = 1'b1; w(Q);
    scl_m = 1'b0; w(1); host_bit = 1'b0; w(Q - 1);
  endtask

  task automatic bit_r(output bit b);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q / 2); b = sda_line; w(Q / 2);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic wbyte(logic [7:0] d, output int ack);
    bit nb;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(nb);
    ack = nb ? 0 : 1;
  endtask

  task automatic rbyte(bit give_ack, output int d);
    bit b;
    d = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_r(b);
      d = (d << 1) | int'(b);
    end
    bit_w(!give_ack);
  endtask

  // checks on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (div_rst) div_seen++;
      if (host_bit) chk("R12 SDA driven during host bit", int'(sda_oe), 0);
      if (pf_settled) chk("R9 SDA driven during power fail", int'(sda_oe), 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ack, d;
    logic [63:0] t1, t2;
    t1 = 64'h2401150614233537;
    t2 = 64'h2401150614245811;
    for (int i = 0; i < 20; i++) mem_m[i] = 0;
    w(4); rst = 1'b0; w(4);

    // R11 reset state
    chk("R11 sda_oe after reset", int'(sda_oe), 0);
    chk("R11 freeze after reset", int'(freeze), 0);
    chk("R11 div_rst after reset", int'(div_rst), 0);
    chk("R11 clock bytes after reset", int'(tk_time == 64'd0), 1);
    bstart(); wbyte(8'hD1, ack); chk("R1 read address acked", ack, 1);
    rbyte(0, d); chk("R11 pointer 0 after reset", d, mem_m[0]); bstop();

    // R1 foreign addresses
    bstart(); wbyte(8'hA0, ack); chk("R1 A0h not acked", ack, 0);
    wbyte(8'h08, ack); chk("R1 silent after foreign address", ack, 0); bstop();
    bstart(); wbyte(8'hD2, ack); chk("R1 D2h not acked", ack, 0); bstop();

    // R2 write with pointer load, R3 random read
    bstart(); wbyte(8'hD0, ack); chk("R1 write address acked", ack, 1);
    wbyte(8'h08, ack); ptr_m = 8; chk("R2 word address acked", ack, 1);
    wbyte(8'h5A, ack); m_wr(8, 'h5A); chk("R2 data acked", ack, 1);
    wbyte(8'h3C, ack); m_wr(9, 'h3C); chk("R2 second data acked", ack, 1);
    bstop();
    bstart(); wbyte(8'hD0, ack); wbyte(8'h08, ack); ptr_m = 8;
    bstart(); wbyte(8'hD1, ack); chk("R3 read after repeated start acked", ack, 1);
    rbyte(1, d); chk("R3 first read byte", d, mem_m[8]); ptr_m = 9;
    rbyte(0, d); chk("R3 next byte after ACK", d, mem_m[9]);
    w(2); chk("R10 SDA released after NACK", int'(sda_oe), 0);
    bstop();

    // R4 read without word address; NACK kept pointer at 9
    bstart(); wbyte(8'hD1, ack); rbyte(0, d); chk("R4 read from held pointer", d, mem_m[ptr_m]); bstop();

    // R5 wrap
    bstart(); wbyte(8'hD0, ack); wbyte(8'h13, ack); ptr_m = 19;
    wbyte(8'h77, ack); m_wr(19, 'h77); bstop();
    chk("R5 pointer wrapped to 0", ptr_m, 0);
    bstart(); wbyte(8'hD0, ack); wbyte(8'h13, ack); ptr_m = 19;
    bstart(); wbyte(8'hD1, ack);
    rbyte(1, d); chk("R5 byte 13h", d, mem_m[19]);
    rbyte(0, d); chk("R5 byte after 13h is 00h", d, mem_m[0]); ptr_m = 0;
    bstop();

    // R2 out-of-range word address loads 0
    bstart(); wbyte(8'hD0, ack); wbyte(8'h30, ack); ptr_m = 0;
    bstart(); wbyte(8'hD1, ack); rbyte(0, d); chk("R2 word address 30h reads byte 0", d, mem_m[0]); bstop();

    // R8 update applied when idle; R6 clock writes
    apply_upd(t1, 0);
    chk("R8 update taken when not frozen", int'(tk_time == t1), 1);
    bstart(); wbyte(8'hD0, ack); wbyte(8'h02, ack); ptr_m = 2;
    wbyte(8'h45, ack); m_wr(2, 'h45); bstop(); w(4);
    chk("R6 one divider pulse", div_seen, div_exp);
    chk("R6 byte 2 written", int'(tk_time[23:16]), 'h45);
    chk("R6 hundredths cleared", int'(tk_time[7:0]), 0);
    bstart(); wbyte(8'hD0, ack); wbyte(8'h00, ack); ptr_m = 0;
    wbyte(8'h99, ack); m_wr(0, 'h99); bstop(); w(4);
    chk("R6 byte 0 only takes 00h", int'(tk_time[7:0]), 0);
    chk("R6 divider pulse count", div_seen, div_exp);
    bstart(); wbyte(8'hD0, ack); wbyte(8'h00, ack); ptr_m = 0;
    bstart(); wbyte(8'hD1, ack);
    for (int i = 0; i < 3; i++) begin
      rbyte(i < 2, d); chk("R6 clock byte readback", d, mem_m[i]);
      if (i < 2) ptr_m++;
    end
    bstop();

    // R7 flag and reserved bytes
    bstart(); wbyte(8'hD0, ack); wbyte(8'h0F, ack); ptr_m = 15;
    wbyte(8'hFF, ack); m_wr(15, 'hFF); chk("R7 write to flags acked", ack, 1);
    wbyte(8'hFF, ack); m_wr(16, 'hFF); bstop();
    bstart(); wbyte(8'hD0, ack); wbyte(8'h0F, ack); ptr_m = 15;
    bstart(); wbyte(8'hD1, ack);
    rbyte(1, d); chk("R7 flag byte reads 00h", d, 0);
    rbyte(0, d); chk("R7 reserved byte reads 00h", d, 0); ptr_m = 16;
    bstop();

    // R8 freeze while reading clock bytes
    bstart(); wbyte(8'hD0, ack); wbyte(8'h06, ack); ptr_m = 6;
    bstart(); wbyte(8'hD1, ack);
    chk("R8 freeze high on clock bytes", int'(freeze), 1);
    apply_upd(t2, 1);
    chk("R8 update dropped while frozen", int'(tk_time == t1 || tk_time[23:16] == 8'h45), 1);
    rbyte(1, d); chk("R8 byte 6 frozen", d, mem_m[6]); ptr_m = 7;
    chk("R8 freeze still high at byte 7", int'(freeze), 1);
    rbyte(1, d); chk("R8 byte 7 frozen", d, mem_m[7]); ptr_m = 8;
    chk("R8 freeze low once pointer reaches 8", int'(freeze), 0);
    rbyte(0, d); chk("R8 byte 8", d, mem_m[8]);
    bstop(); w(2);
    chk("R8 freeze low after STOP", int'(freeze), 0);
    apply_upd(t2, 0);
    chk("R8 update taken after STOP", int'(tk_time == t2), 1);
    bstart(); wbyte(8'hD0, ack); wbyte(8'h06, ack); ptr_m = 6;
    bstart(); wbyte(8'hD1, ack); rbyte(0, d); chk("R8 fresh byte 6", d, mem_m[6]); bstop();

    // R9 power fail
    bstart(); wbyte(8'hD0, ack); wbyte(8'h0A, ack); ptr_m = 10;
    pf = 1'b1; w(5); pf_settled = 1'b1;
    chk("R9 SDA released", int'(sda_oe), 0);
    wbyte(8'h55, ack); chk("R9 byte not acked", ack, 0); bstop();
    bstart(); wbyte(8'hD0, ack); chk("R9 address ignored", ack, 0); bstop();
    pf_settled = 1'b0; pf = 1'b0; w(8); ptr_m = 0;
    bstart(); wbyte(8'hD1, ack); rbyte(0, d); chk("R9 pointer reset to 0", d, mem_m[0]); bstop();
    bstart(); wbyte(8'hD0, ack); wbyte(8'h0A, ack); ptr_m = 10;
    bstart(); wbyte(8'hD1, ack); rbyte(0, d); chk("R9 aborted byte not written", d, mem_m[10]); bstop();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule